// File: doc/BRIEF.md
# DMA Channel Programming Registers

This block holds the CPU-visible set-up state of a simple DMA channel: a transfer count with a direction flag and an enable flag, and a word address. A DMA engine elsewhere reads the count, direction, enable and address from this block's outputs. The engine does the transfers and the memory accesses. This block only holds the set-up values.

The CPU programs the count through the data bus. The address is not taken from the data bus. It is taken from the CPU address lines of the write. Address bit 14 of that write chooses which half of the DMA address is loaded, so two writes place a full 22-bit word address.

A count write that selects the memory-write direction also requests a single dummy transfer. It raises a one-cycle request pulse, and the stored count is the written value plus one. Reading the count returns it with the two top bits forced to 1.

Top module: `dma_prog_regs`

## Requirements
- R1: After reset, the outputs are as follows: count is 0, direction is 0, enable is 0, DMA address is 0, dummy request is 0, and read data is 0xC000.
- R2: A count write (`wr_en`=1, `reg_sel`=0) behaves as follows when data bit 14 is 1. On the next clock, count takes data bits 13:0, `dir_rd` takes bit 14 and `dma_en` takes bit 15.
- R3: A count write with data bit 14 equal to 0 behaves as follows. Count takes data bits 13:0 plus one, `dir_rd` becomes 0, and `dummy_req` is high for exactly the one cycle that follows the write.
- R4: The count is 14 bits wide. When the dummy increment is applied to 0x3FFF, the count wraps to 0.
- R5: `rd_data` always equals {2'b11, count[13:0]}.
- R6: An address write (`wr_en`=1, `reg_sel`=1) with `cpu_addr[14]`=1 loads DMA address bits 21:9 from `cpu_addr[13:1]`. DMA address bits 8:0 are unchanged.
- R7: An address write with `cpu_addr[14]`=0 loads DMA address bits 8:1 from `cpu_addr[8:1]`. DMA address bits 21:9 are unchanged.
- R8: DMA address bit 0 is always 0, whatever the value of `cpu_addr[0]`.
- R9: A cycle with `wr_en`=0 changes no output. A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the count register, 1 selects the address register |
| cpu_addr | input | 15 | CPU address bits 14:0 of the write |
| wr_data | input | 16 | CPU write data |
| rd_data | output | 16 | Count readback, with the top two bits forced to 1 |
| count | output | 14 | Current transfer count |
| dir_rd | output | 1 | Transfer direction: 1 = read from memory |
| dma_en | output | 1 | DMA enable |
| dma_addr | output | 22 | DMA word address, always even |
| dummy_req | output | 1 | One-cycle request for a dummy write transfer |

## Verification
Every stored field appears directly on an output, so a wrong internal state shows up at the ports on the first negative edge after the write that caused it. Neither register has any hidden state. The risks are a half of the address being overwritten when the other half is loaded, a missing or misplaced increment, and a dummy pulse that lasts too long or appears after a direction-1 write. Each of these shows up within one cycle on `dma_addr`, `count` or `dummy_req`.

// File: rtl/dma_prog_regs.sv
module dma_prog_regs #(
  parameter int CNT_W = 14,
  parameter int HI_W  = 13,
  parameter int LO_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  reg_sel,
  input  logic [HI_W+1:0]       cpu_addr,
  input  logic [CNT_W+1:0]      wr_data,
  output logic [CNT_W+1:0]      rd_data,
  output logic [CNT_W-1:0]      count,
  output logic                  dir_rd,
  output logic                  dma_en,
  output logic [HI_W+LO_W:0]    dma_addr,
  output logic                  dummy_req
);
  localparam int HALF_BIT = HI_W + 1;
  localparam int AW       = HI_W + LO_W + 1;

  logic [HI_W-1:0] addr_hi;
  logic [LO_W-1:0] addr_lo;
  logic            cnt_wr, adr_wr;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_wr   = wr_en && !reg_sel;
  assign adr_wr   = wr_en && reg_sel;
  assign cnt_next = wr_data[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, !wr_data[CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      dir_rd    <= 1'b0;
      dma_en    <= 1'b0;
      dummy_req <= 1'b0;
    end else begin
      dummy_req <= cnt_wr && !wr_data[CNT_W];
      if (cnt_wr) begin
        count  <= cnt_next;
        dir_rd <= wr_data[CNT_W];
        dma_en <= wr_data[CNT_W+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hi <= '0;
      addr_lo <= '0;
    end else if (adr_wr) begin
      if (cpu_addr[HALF_BIT]) addr_hi <= cpu_addr[HI_W:1];
      else                    addr_lo <= cpu_addr[LO_W:1];
    end
  end

  assign dma_addr = {addr_hi, addr_lo, 1'b0};
  assign rd_data  = {2'b11, count};

  logic unused_ok;
  assign unused_ok = ^{cpu_addr[0], AW[0]};
endmodule

module dma_prog_regs_chk #(
  parameter int CNT_W = 14,
  parameter int HI_W  = 13,
  parameter int LO_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 reg_sel,
  input logic [HI_W+1:0]      cpu_addr,
  input logic [CNT_W+1:0]     wr_data,
  input logic [CNT_W+1:0]     rd_data,
  input logic [CNT_W-1:0]     count,
  input logic                 dir_rd,
  input logic                 dma_en,
  input logic [HI_W+LO_W:0]   dma_addr,
  input logic                 dummy_req
);
  assert_dummy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_req |-> $past(wr_en && !reg_sel && !wr_data[CNT_W]));

  assert_dir_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (dir_rd == $past(wr_data[CNT_W]) && dma_en == $past(wr_data[CNT_W+1])));

  assert_read_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CNT_W+1:CNT_W] == 2'b11 && rd_data[CNT_W-1:0] == count);

  assert_even_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_addr[0] == 1'b0);

  assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && cpu_addr[HI_W+1]) |=> $stable(dma_addr[LO_W:0]));

  assert_lo_keeps_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !cpu_addr[HI_W+1]) |=> $stable(dma_addr[HI_W+LO_W:LO_W+1]));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || reg_sel) |=> ($stable(count) && $stable(dir_rd) && $stable(dma_en)));
endmodule

bind dma_prog_regs dma_prog_regs_chk #(.CNT_W(CNT_W), .HI_W(HI_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/dma_prog_regs_tb.sv
module dma_prog_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        reg_sel = 0;
  logic [14:0] cpu_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [13:0] count;
  logic        dir_rd, dma_en, dummy_req;
  logic [21:0] dma_addr;

  always #5 clk = ~clk;

  dma_prog_regs u_dut (.*);

  int vectors = 0;
  int fails = 0;
  logic [40:0] exp_q[$];
  string       tag_q[$];

  logic [13:0] m_cnt = '0;
  logic        m_dir = 0, m_en = 0;
  logic [21:0] m_addr = '0;

  function automatic logic [40:0] pack(input logic dmy);
    return {{2'b11, m_cnt}, m_dir, m_en, m_addr, dmy};
  endfunction

  task automatic cmp(input string tag, input string f, input logic [31:0] a, input logic [31:0] e);
    vectors++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, f, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [40:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "rd_data",   32'(rd_data),   32'(e[40:25]));
      cmp(t, "dir_rd",    32'(dir_rd),    32'(e[24]));
      cmp(t, "dma_en",    32'(dma_en),    32'(e[23]));
      cmp(t, "dma_addr",  32'(dma_addr),  32'(e[22:1]));
      cmp(t, "dummy_req", 32'(dummy_req), 32'(e[0]));
      cmp(t, "count",     32'(count),     32'(e[40:25] & 16'h3FFF));
    end
  end

  task automatic idle(input string tag);
    @(negedge clk);
    wr_en = 0;
    cpu_addr = 15'h7FFF;
    wr_data = 16'h1234;
    @(posedge clk);
    #1;
    exp_q.push_back(pack(1'b0));
    tag_q.push_back(tag);
  endtask

  task automatic wr_cnt(input logic [15:0] d, input string tag);
    @(negedge clk);
    wr_en = 1; reg_sel = 0; wr_data = d; cpu_addr = 15'h4ABC;
    m_cnt = d[14] ? d[13:0] : d[13:0] + 14'd1;
    m_dir = d[14];
    m_en  = d[15];
    @(posedge clk);
    #1;
    exp_q.push_back(pack(!d[14]));
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_adr(input logic [14:0] a, input string tag);
    @(negedge clk);
    wr_en = 1; reg_sel = 1; cpu_addr = a; wr_data = 16'hFFFF;
    if (a[14]) m_addr[21:9] = a[13:1];
    else       m_addr[8:1]  = a[8:1];
    @(posedge clk);
    #1;
    exp_q.push_back(pack(1'b0));
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R1 reset state");
    wr_cnt(16'hC123, "R2 count dir1 en1");
    idle("R3 no dummy after dir1");
    wr_cnt(16'h0005, "R3 dummy increment");
    idle("R3 dummy lasts one cycle");
    wr_cnt(16'h3FFF, "R4 wrap to zero");
    wr_cnt(16'h7FFF, "R4 dir1 no increment");
    wr_cnt(16'h8000, "R5 readback forced top bits");
    wr_adr(15'h6AAB, "R6 upper half load");
    wr_adr(15'h01FF, "R7 lower half load R8 bit0");
    wr_adr(15'h4002, "R6 upper reload keeps lower");
    wr_adr(15'h0000, "R7 lower clear keeps upper");
    wr_cnt(16'h4AAA, "R9 count write leaves address");
    wr_adr(15'h7FFF, "R9 address write leaves count");
    idle("R9 idle no change");
    idle("R9 idle no change again");
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule